// File: doc/BRIEF.md
# Rotate Unit with Carry Participation

This block rotates a 16-bit operand by a variable count in one of four ways: plain rotate left, plain rotate right, rotate left through carry and rotate right through carry. In the plain modes, bits that leave one end of the operand come back in at the other end. In the through-carry modes, the incoming carry flag is joined to the operand. The resulting 17-bit ring then rotates as a whole.

The unit is purely combinational. An execution stage drives the operand, the current carry flag, a 2-bit operation code and a count. In the same cycle it takes back the rotated value, the new carry flag and a strobe that says whether the carry flag should be written. Only the low five bits of the count are used.

Top module: `rotc_unit`

## Requirements
- R1: With op_i = 2'b00 the result is opnd_i rotated left by the masked count modulo 16.
- R2: With op_i = 2'b01 the result is opnd_i rotated right by the masked count modulo 16.
- R3: In the plain modes (op_i = 2'b00 or 2'b01) with a non-zero masked count, carry_o equals the last bit rotated out: result bit 0 for a left rotate and result bit 15 for a right rotate.
- R4: With op_i = 2'b10 the 17-bit ring {carry_i, opnd_i} rotates left by the masked count modulo 17. res_o is the low 16 bits of the ring and carry_o is bit 16. For example, carry 1 with operand 4020H rotated by 5 gives 0414H with carry 0.
- R5: With op_i = 2'b11 the same 17-bit ring rotates right by the masked count modulo 17, and the outputs are taken as in R4.
- R6: Only cnt_i[4:0] is used. Bits 7:5 of the count have no effect on any output.
- R7: In the through-carry modes a masked count of 17 leaves the result and carry equal to the inputs, while flag_upd_o is still 1.
- R8: When the masked count is zero, res_o = opnd_i, carry_o = carry_i and flag_upd_o = 0, in every mode.
- R9: flag_upd_o is 1 whenever the masked count is non-zero.
- R10: All outputs follow the inputs combinationally, within the same cycle and with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 16 | Operand to rotate |
| carry_i | input | 1 | Incoming carry flag |
| op_i | input | 2 | Operation: 0 ROL, 1 ROR, 2 RCL, 3 RCR |
| cnt_i | input | 8 | Rotate count; only the low 5 bits are used |
| res_o | output | 16 | Rotated result |
| carry_o | output | 1 | Outgoing carry flag |
| flag_upd_o | output | 1 | High when the carry flag should be written |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The bench drives a new input set just after a rising edge of its own clock and samples the outputs at the next falling edge. By then the combinational paths have settled, and no next stimulus has arrived. The expected values come from a reference that rotates one bit position per step, for as many steps as the masked count.

// File: rtl/rotc_pkg.sv
package rotc_pkg;
  typedef enum logic [1:0] {
    OP_ROL = 2'd0,
    OP_ROR = 2'd1,
    OP_RCL = 2'd2,
    OP_RCR = 2'd3
  } rot_op_e;
endpackage

// File: rtl/rotc_amount.sv
// Reduces a masked count to a left-rotate amount for a ring of RING_W bits.
module rotc_amount #(
  parameter int RING_W = 16,
  parameter int CNT_W  = 5,
  localparam int AMT_W = $clog2(RING_W)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             right_i,
  output logic [AMT_W-1:0] amt_o
);
  int unsigned m;

  always_comb begin
    m = int'(cnt_i) % RING_W;
    // a right rotate by m equals a left rotate by RING_W - m
    if (right_i && m != 0) m = RING_W - m;
    amt_o = AMT_W'(m);
  end

  always_comb begin
    AST_AMT_IN_RING: assert (int'(amt_o) < RING_W) else $error("amount out of ring"); // R7
  end
endmodule

// File: rtl/rotc_ring.sv
// Logarithmic left rotator over a RING_W-bit ring.
module rotc_ring #(
  parameter int RING_W = 16,
  localparam int AMT_W = $clog2(RING_W)
) (
  input  logic [RING_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [RING_W-1:0] data_o
);
  logic [RING_W-1:0] stg [AMT_W+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [RING_W-1:0] rot;
    assign rot        = {stg[s][RING_W-1-SH:0], stg[s][RING_W-1:RING_W-SH]};
    assign stg[s+1]   = amt_i[s] ? rot : stg[s];
  end

  assign data_o = stg[AMT_W];

  always_comb begin
    AST_BITS_KEPT: assert ($countones(data_o) == $countones(data_i)) else $error("ring lost bits"); // R1
  end
endmodule

// File: rtl/rotc_unit.sv
module rotc_unit #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic [1:0]        op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              flag_upd_o
);
  import rotc_pkg::*;

  localparam int CRING_W = DATA_W + 1;
  localparam int PA_W    = $clog2(DATA_W);
  localparam int CA_W    = $clog2(CRING_W);

  rot_op_e           op;
  logic [MASK_W-1:0] cnt_m;
  logic              unused_cnt_hi;
  logic              thru, right;
  logic [PA_W-1:0]   p_amt;
  logic [CA_W-1:0]   c_amt;
  logic [DATA_W-1:0] p_out;
  logic [CRING_W-1:0] c_out;

  assign op            = rot_op_e'(op_i);
  assign cnt_m         = cnt_i[MASK_W-1:0];
  assign unused_cnt_hi = ^cnt_i[CNT_W-1:MASK_W];
  assign thru          = (op == OP_RCL) || (op == OP_RCR);
  assign right         = (op == OP_ROR) || (op == OP_RCR);

  rotc_amount #(.RING_W(DATA_W), .CNT_W(MASK_W)) u_p_amt (
    .cnt_i(cnt_m), .right_i(right), .amt_o(p_amt)
  );
  rotc_amount #(.RING_W(CRING_W), .CNT_W(MASK_W)) u_c_amt (
    .cnt_i(cnt_m), .right_i(right), .amt_o(c_amt)
  );

  rotc_ring #(.RING_W(DATA_W)) u_p_ring (
    .data_i(opnd_i), .amt_i(p_amt), .data_o(p_out)
  );
  rotc_ring #(.RING_W(CRING_W)) u_c_ring (
    .data_i({carry_i, opnd_i}), .amt_i(c_amt), .data_o(c_out)
  );

  always_comb begin
    res_o      = opnd_i;
    carry_o    = carry_i;
    flag_upd_o = 1'b0;
    if (cnt_m != '0) begin
      flag_upd_o = 1'b1;
      if (thru) begin
        res_o   = c_out[DATA_W-1:0];
        carry_o = c_out[DATA_W];
      end else begin
        res_o   = p_out;
        // last bit out lands at the end the ring wrapped into
        carry_o = right ? p_out[DATA_W-1] : p_out[0];
      end
    end
  end

  always_comb begin
    AST_ZERO_HOLD: assert (cnt_i[MASK_W-1:0] != '0 ||
                           (res_o == opnd_i && carry_o == carry_i && !flag_upd_o))
      else $error("zero count changed state"); // R8
    AST_UPD_NONZERO: assert (!flag_upd_o || cnt_i[MASK_W-1:0] != '0)
      else $error("update without count"); // R9
    AST_THRU_BITS: assert (!thru ||
                           $countones({carry_o, res_o}) == $countones({carry_i, opnd_i}))
      else $error("carry ring lost bits"); // R4
    AST_PLAIN_BITS: assert (thru || $countones(res_o) == $countones(opnd_i))
      else $error("plain ring lost bits"); // R2
  end
endmodule

// File: tb/rotc_unit_tb.sv
module rotc_unit_tb;
  logic        clk = 1'b0;
  logic [15:0] opnd_i = '0;
  logic        carry_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [15:0] res_o;
  logic        carry_o;
  logic        flag_upd_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rotc_unit u_dut (
    .opnd_i(opnd_i), .carry_i(carry_i), .op_i(op_i), .cnt_i(cnt_i),
    .res_o(res_o), .carry_o(carry_o), .flag_upd_o(flag_upd_o)
  );

  // bit-by-bit reference: returns {upd, carry, result}
  function automatic logic [17:0] ref_rot(logic [1:0] op, logic [15:0] d, logic c, logic [7:0] cnt);
    int k = int'(cnt[4:0]);
    logic [15:0] r = d;
    logic cf = c;
    for (int i = 0; i < k; i++) begin
      case (op)
        2'd0: begin cf = r[15]; r = {r[14:0], r[15]}; end
        2'd1: begin cf = r[0];  r = {r[0], r[15:1]}; end
        2'd2: begin {cf, r} = {r, cf}; end
        default: begin {r, cf} = {cf, r}; end
      endcase
    end
    return {k != 0, cf, r};
  endfunction

  task automatic apply_check(string req, logic [1:0] op, logic [15:0] d, logic c, logic [7:0] cnt);
    logic [17:0] exp;
    @(posedge clk);
    #1;
    op_i = op; opnd_i = d; carry_i = c; cnt_i = cnt;
    exp = ref_rot(op, d, c, cnt);
    @(negedge clk);
    total++;
    if ({flag_upd_o, carry_o, res_o} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d d=%h c=%b cnt=%h: actual upd=%b cf=%b res=%h expected upd=%b cf=%b res=%h",
               req, op, d, c, cnt, flag_upd_o, carry_o, res_o, exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic expect_val(string req, logic [17:0] exp);
    total++;
    if ({flag_upd_o, carry_o, res_o} !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, {flag_upd_o, carry_o, res_o}, exp);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    expect_val("R8 idle", 18'h0);
  endtask

  task automatic t_example();
    apply_check("R4 example", 2'd2, 16'h4020, 1'b1, 8'd5);
    expect_val("R4 example fixed", {1'b1, 1'b0, 16'h0414});
  endtask

  task automatic t_sweep(string req, logic [1:0] op);
    logic [15:0] pats [4] = '{16'h8001, 16'h4020, 16'hA5C3, 16'h0001};
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 32; k++)
        apply_check(req, op, pats[p], p[0], 8'(k));
  endtask

  task automatic t_mask();
    for (int op = 0; op < 4; op++) begin
      apply_check("R6 high bits", 2'(op), 16'h1234, 1'b1, 8'hE5);
      expect_val("R6 same as 5", ref_rot(2'(op), 16'h1234, 1'b1, 8'h05));
      apply_check("R8 masked zero", 2'(op), 16'hBEEF, 1'b1, 8'hA0);
      expect_val("R8 hold", {1'b0, 1'b1, 16'hBEEF});
    end
  endtask

  task automatic t_full_ring();
    apply_check("R7 rcl 17", 2'd2, 16'hC0DE, 1'b1, 8'd17);
    expect_val("R7 rcl 17 fixed", {1'b1, 1'b1, 16'hC0DE});
    apply_check("R7 rcr 17", 2'd3, 16'h0F0F, 1'b0, 8'd17);
    expect_val("R7 rcr 17 fixed", {1'b1, 1'b0, 16'h0F0F});
    apply_check("R3 rol 16", 2'd0, 16'h0001, 1'b0, 8'd16);
    expect_val("R3 rol 16 fixed", {1'b1, 1'b1, 16'h0001});
    apply_check("R9 ror 1", 2'd1, 16'h0001, 1'b0, 8'd1);
    expect_val("R9 R3 ror 1 fixed", {1'b1, 1'b1, 16'h8000});
  endtask

  task automatic t_comb();
    // R10: change inputs without any clock edge and look 1 ns later
    #1;
    op_i = 2'd0; opnd_i = 16'h0003; carry_i = 1'b0; cnt_i = 8'd1;
    #1;
    expect_val("R10 comb", {1'b1, 1'b0, 16'h0006});
  endtask

  initial begin
    t_idle();
    t_example();
    t_sweep("R1 rol", 2'd0);
    t_sweep("R2 ror", 2'd1);
    t_sweep("R4 rcl", 2'd2);
    t_sweep("R5 rcr", 2'd3);
    t_mask();
    t_full_ring();
    t_comb();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule